// File: doc/BRIEF.md
# Iterative Half-Adder Completion Adder

This block adds two unsigned operands without a carry-propagation chain. Every bit position has one half-adder. A two-input selector in front of each half-adder picks its inputs. On the first clock edge of an operation the half-adders take the operand bits. On every later edge they take the previous sum vector and the previous carry vector moved up by one bit.

The loop runs until the carry vector is all zero. At that point the sum vector holds the result, and an active-high completion flag is raised. The flag is the inverted OR of the carry bits.

Latency therefore depends on the data. Carry chains that do not touch each other are resolved in the same passes. The longest chain decides how long an addition takes.

A requester drives the operands, raises `req` and holds it until `done` rises. It then reads `sum` and `cout`, and drops `req` to return the block to idle. Each loop iteration takes one clock edge. This is a synchronous model of the self-timed behaviour.

Top module: `halfadd_loop_adder`

## Requirements
- R1: While reset is active and after it is released with `req` low, `sum` is 0, `cout` is 0 and `done` is 0.
- R2: On a rising clock edge where `req` is high and the block is idle, the operands are captured through the first half-add pass. If `opa & opb` is zero, `done` is high right after that single edge. For example, 0x10 + 0x0C gives `sum` 0x1C after one edge.
- R3: When `done` is high, {`cout`,`sum`} equals `opa` + `opb` as applied at the accepting edge.
- R4: `done` goes high no later than WIDTH+1 edges after the accepting edge, counting that edge. The worst case, 0xFF + 0x01, takes exactly 9 edges.
- R5: A carry that leaves the top bit sets the sticky `cout`. It is never fed back into bit 0. For example, 0xFF + 0xFF gives `sum` 0xFE and `cout` 1.
- R6: One edge after `req` is sampled low, `done` is 0.
- R7: While `req` stays high after `done`, changes on `opa`/`opb` are ignored. `sum`, `cout` and `done` hold.
- R8: Disjoint carry chains resolve in the same passes. The latency is one edge plus one pass per bit of the longest chain. For example, 0x11 + 0x11 takes 2 edges and 0x0F + 0x01 takes 5 edges.
- R9: If `req` drops before `done`, the operation is abandoned and `done` stays 0. The next request loads fresh operands and gives their correct sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one loop iteration per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request; drives the feedback selector, held high for one operation |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| sum | output | WIDTH | Result bits, valid while `done` is high |
| cout | output | 1 | Sticky carry out of the top bit |
| done | output | 1 | Completion flag, high when the carry vector is all zero |

## Verification
Two actions can land in the same cycle:
- the accepting edge completes the whole addition, because the operands share no set bit;
- the top carry leaves the word on the same pass that empties the carry vector.

The bench provokes the first case with the 0x10 + 0x0C vector and similar disjoint operands. It judges that `done` is visible one edge after acceptance, with the right sum.

It provokes the second case with 0x80 + 0x80 and 0xFF + 0xFF. It checks that `cout` is set on the same edge that completion appears, and that bit 0 of the sum shows no wrapped-around carry.

A scoreboard also compares random operand pairs against their integer sum, with the latency bound checked each time.

// File: rtl/halfadd_loop_adder.sv
module halfadd_loop_adder #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             done
);

  localparam int TW = WIDTH + 2;

  logic             sel;
  logic [WIDTH-1:0] sum_q;
  logic [WIDTH-1:0] cry_q;
  logic             cout_q;

  wire [WIDTH-1:0] ha_x = sel ? sum_q : opa;
  wire [WIDTH-1:0] ha_y = sel ? {cry_q[WIDTH-2:0], 1'b0} : opb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel    <= 1'b0;
      sum_q  <= '0;
      cry_q  <= '0;
      cout_q <= 1'b0;
    end else if (!req) begin
      sel <= 1'b0;
    end else begin
      if (!sel) begin
        sel    <= 1'b1;
        cout_q <= 1'b0;
      end else begin
        cout_q <= cout_q | cry_q[WIDTH-1];
      end
      sum_q <= ha_x ^ ha_y;
      cry_q <= ha_x & ha_y;
    end
  end

  assign sum  = sum_q;
  assign cout = cout_q;
  assign done = sel & ~|cry_q;

  wire [TW-1:0] total = TW'(sum_q) + (TW'(cry_q) << 1) + (TW'(cout_q) << WIDTH);

  // R2
  load_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && req) |=> (total == (TW'($past(opa)) + TW'($past(opb)))) && !cout_q);

  // R3
  iter_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && req) |=> total == $past(total));

  // R5
  cout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && req && cout_q) |=> cout_q);

  // R6
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !done);

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req) |=> done && $stable(sum) && $stable(cout));

endmodule

// File: tb/halfadd_loop_adder_tb_top.sv
module halfadd_loop_adder_tb_top;
  localparam int W     = 8;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] sum;
  logic         cout, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [W:0] exp;
    int         exact_lat;
    string      tag;
  } item_t;

  item_t sbq[$];

  always #(CLK_P/2) clk = ~clk;

  halfadd_loop_adder #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .opa(opa), .opb(opb),
    .sum(sum), .cout(cout), .done(done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: sample a quarter period after each rising edge
  int  lat = 0;
  bit  seen = 0;
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (!req) begin
      lat  = 0;
      seen = 0;
    end else if (!seen) begin
      lat++;
      if (done) begin
        seen = 1;
        if (sbq.size() > 0) begin
          item_t it;
          it = sbq.pop_front();
          check({cout, sum} == it.exp, {it.tag, " R3 result"}, {cout, sum}, it.exp);
          check(lat <= W + 1, {it.tag, " R4 latency bound"}, lat, W + 1);
          if (it.exact_lat > 0)
            check(lat == it.exact_lat, {it.tag, " R8 latency"}, lat, it.exact_lat);
        end
      end
    end
  end

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input int exact_lat, input string tag);
    item_t it;
    int    n;
    it.exp = {1'b0, a} + {1'b0, b};
    it.exact_lat = exact_lat;
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    opa = a; opb = b; req = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 4 * W);
    check(done == 1'b1, {tag, " R4 done seen"}, done, 1);
    // R7: disturb operands while holding req
    opa = ~a; opb = a ^ b;
    repeat (2) @(negedge clk);
    check({cout, sum} == it.exp && done, {tag, " R7 hold"}, {done, cout, sum}, {1'b1, it.exp});
    req = 1'b0;
    @(posedge clk);
    #(CLK_P/4);
    check(done == 1'b0, {tag, " R6 done clears"}, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sum == '0 && cout == 1'b0 && done == 1'b0, "R1 in reset", {done, cout, sum}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sum == '0 && cout == 1'b0 && done == 1'b0, "R1 after reset", {done, cout, sum}, 0);

    // R2 reference vector, completes on the accepting edge
    run_op(8'h10, 8'h0C, 1, "R2 vec");
    check(sum == 8'h1C, "R2 sum 1C", sum, 8'h1C);
    run_op(8'hA5, 8'h5A, 1, "R2 disjoint");

    // R4 worst case
    run_op(8'hFF, 8'h01, W + 1, "R4 worst");
    check(cout == 1'b1 && sum == 8'h00, "R5 worst cout", {cout, sum}, 9'h100);

    // R5 carry leaves top on final pass; no wrap into bit 0
    run_op(8'h80, 8'h80, 2, "R5 top");
    run_op(8'hFF, 8'hFF, 2, "R5 nowrap");
    check(sum[0] == 1'b0, "R5 bit0 clear", sum[0], 0);

    // R8 parallel chains
    run_op(8'h11, 8'h11, 2, "R8 pair");
    run_op(8'h0F, 8'h01, 5, "R8 chain4");

    // R9 abort then fresh operands
    @(negedge clk);
    opa = 8'hFF; opb = 8'h01; req = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R9 not done mid-loop", done, 0);
    req = 1'b0;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R9 abandoned", done, 0);
    run_op(8'h3C, 8'h0F, 0, "R9 fresh");

    // random scoreboard traffic
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      run_op(ra, rb, 0, "R3 rand");
    end

    check(sbq.size() == 0, "R3 scoreboard drained", sbq.size(), 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R4 actual=timeout expected=finish");
    finish_run();
  end
endmodule